// File: doc/BRIEF.md
# Processor Bus Cycle Issuer with Locking

This block sits between the internal request logic of a 32-bit processor-style bus master and its external bus. It takes one cycle request at a time. Each request carries an operation code, a word address, active-low byte enables and three flags: locked, last-of-lock and more-to-follow. The block turns the request into a bus cycle with a one-clock address phase, marked by the address strobe, and a data phase that lasts until the ready input is seen low. The operation code selects one of the standard cycle definitions or one of three special cycles: Shutdown, Halt and Stop Grant. Special cycles are told apart by their byte enables and the three lowest address bits.

Two lock outputs follow different rules. The bus lock covers a whole sequence of locked cycles and blocks bus-hold grants while it is active. The pseudo-lock marks a transaction of several cycles and releases as soon as the last cycle's address is driven. A bus-hold request floats the driven outputs and is acknowledged one clock later. A separate address-hold input floats only the address lines and is honoured even during a locked sequence. A cache-fill permission pulse is given at the end of a read when the cacheability input is low, but never for a locked read.

Top module: `bus_cycle_issuer`

## Requirements
- R1: For operation codes 0 to 7, the definition lines {m_io_n, d_c_n, w_r_n} equal the code (0 interrupt acknowledge, 2 I/O read, 3 I/O write, 4 code read, 6 memory read, 7 memory write). The address and byte enables are the requested ones.
- R2: Codes 8, 9 and 10 drive definition 001 with address 0 except bits [2:0] (A4..A2). Code 8 (Shutdown) uses be_n 1110 and low bits 000, code 9 (Halt) uses be_n 1011 and low bits 000, and code 10 (Stop Grant) uses be_n 1011 and low bits 100.
- R3: ads_n is low for exactly one clock, the first clock in which the new address and definition are driven. The address stays stable into the data phase.
- R4: A cycle ends at the first rising edge that samples rdy_n low after the address phase. cyc_done is high in that clock only, so every cycle lasts at least two clocks.
- R5: lock_n goes low in the address phase of the first locked cycle. It goes high in the clock after ready ends a locked cycle flagged last-of-lock, and stays low between the cycles of the sequence.
- R6: While the bus lock is active, a high hold input is not granted: hlda stays 0 and bus_oe stays 1. The hold is granted once the lock is released.
- R7: A high ahold sets addr_oe to 0 at once without changing bus_oe or lock_n, also during a locked sequence.
- R8: plock_n is low from the address phase of a cycle requested with the more flag. It stays low after that cycle ends, whether or not ready has come, and goes high in the address phase of the next cycle requested without the flag.
- R9: fill_ok pulses with cyc_done for a code read or memory read when ken_n is low, and stays 0 for a locked read.
- R10: With the bus idle and no lock, a high hold sets bus_oe to 0 after the next edge, with hlda still 0. hlda rises one clock later, and req_ready is 0 while held. Dropping hold restores bus_oe=1 and hlda=0 after one edge.
- R11: After reset, ads_n, lock_n and plock_n are 1, hlda is 0, bus_oe is 1 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 4 | Operation code |
| req_addr | input | 30 | Word address (A31..A2) |
| req_be_n | input | 4 | Active-low byte enables |
| req_lock | input | 1 | Cycle belongs to a locked sequence |
| req_lock_last | input | 1 | Last cycle of the locked sequence |
| req_more | input | 1 | More cycles follow in this transaction |
| req_ready | output | 1 | Request accepted at this edge |
| rdy_n | input | 1 | Active-low cycle ready |
| ken_n | input | 1 | Active-low cacheable indication |
| hold | input | 1 | Bus hold request |
| ahold | input | 1 | Address hold request |
| ads_n | output | 1 | Address strobe |
| m_io_n | output | 1 | Memory / I/O definition line |
| d_c_n | output | 1 | Data / control definition line |
| w_r_n | output | 1 | Write / read definition line |
| addr | output | 30 | Address A31..A2 |
| be_n | output | 4 | Byte enables |
| lock_n | output | 1 | Bus lock |
| plock_n | output | 1 | Pseudo-lock |
| bus_oe | output | 1 | Control, definition and lock outputs driven |
| addr_oe | output | 1 | Address lines driven |
| hlda | output | 1 | Hold acknowledge |
| cyc_done | output | 1 | Current cycle ends at this edge |
| fill_ok | output | 1 | Cycle may be used as a cache fill |

## Verification
A wrong lock flag shows up as lock_n at the wrong level in the address phase of the next cycle, or in the clock after ready. It can also show as a hold acknowledged during a locked sequence within two clocks of the hold request. A stale pseudo-lock flag is visible on plock_n in the very next address phase. Sequencer errors show as an address strobe that lasts more than one clock, a cyc_done outside the data phase, or an hlda that rises in the same clock as the float instead of one clock later.

// File: rtl/bci_pkg.sv
package bci_pkg;
  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_SHUTDOWN = 4'd8;
  localparam logic [OP_W-1:0] OP_HALT     = 4'd9;
  localparam logic [OP_W-1:0] OP_STOPGNT  = 4'd10;

  localparam logic [2:0] DEFN_SPECIAL = 3'b001;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_DATA  = 3'd2,
    ST_FLOAT = 3'd3,
    ST_HELD  = 3'd4
  } bus_state_e;
endpackage

// File: rtl/bci_encode.sv
module bci_encode
  import bci_pkg::*;
#(
  parameter int AW = 30,
  parameter int BW = 4
) (
  input  logic [OP_W-1:0] op,
  input  logic [AW-1:0]   addr_in,
  input  logic [BW-1:0]   be_in,
  output logic [2:0]      defn,
  output logic [AW-1:0]   addr_out,
  output logic [BW-1:0]   be_out
);
  localparam int SEL_W = 3;

  always_comb begin
    defn     = op[2:0];
    addr_out = addr_in;
    be_out   = be_in;
    if (op[3]) begin
      defn     = DEFN_SPECIAL;
      addr_out = '0;
      be_out   = '1;
      unique case (op)
        OP_SHUTDOWN: be_out[0] = 1'b0;
        OP_HALT:     be_out[2] = 1'b0;
        OP_STOPGNT: begin
          be_out[2]            = 1'b0;
          addr_out[SEL_W-1]    = 1'b1;
        end
        default:     be_out[2] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bci_lock.sv
module bci_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic req_lock,
  input  logic req_lock_last,
  input  logic req_more,
  input  logic cyc_end,
  output logic lock_q,
  output logic lock_nx,
  output logic cur_lock_q,
  output logic plock_q
);
  logic cur_last_q;
  logic cur_last_d, cur_lock_d, plock_d;

  always_comb begin
    lock_nx    = lock_q;
    cur_last_d = cur_last_q;
    cur_lock_d = cur_lock_q;
    plock_d    = plock_q;
    if (accept) begin
      cur_last_d = req_lock & req_lock_last;
      cur_lock_d = req_lock;
      plock_d    = req_more;
      if (req_lock) lock_nx = 1'b1;
    end else if (cyc_end && cur_last_q) begin
      lock_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q     <= 1'b0;
      cur_last_q <= 1'b0;
      cur_lock_q <= 1'b0;
      plock_q    <= 1'b0;
    end else begin
      lock_q     <= lock_nx;
      cur_last_q <= cur_last_d;
      cur_lock_q <= cur_lock_d;
      plock_q    <= plock_d;
    end
  end

  // R5
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !cyc_end && !accept) |=> lock_q);
endmodule

// File: rtl/bci_seq.sv
module bci_seq
  import bci_pkg::*;
#(
  parameter int AW = 30,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    enc_defn,
  input  logic [AW-1:0] enc_addr,
  input  logic [BW-1:0] enc_be,
  input  logic          rdy_n,
  input  logic          hold,
  input  logic          lock_q,
  input  logic          lock_nx,
  output logic          accept,
  output logic          req_ready,
  output logic          in_addr,
  output logic          cyc_end,
  output logic          bus_oe,
  output logic          hlda,
  output logic [2:0]    defn_q,
  output logic [AW-1:0] addr_q,
  output logic [BW-1:0] be_q
);
  bus_state_e state_q, state_d;

  assign req_ready = (state_q == ST_IDLE) && !(hold && !lock_q);
  assign accept    = req_ready && req_valid;
  assign in_addr   = (state_q == ST_ADDR);
  assign cyc_end   = (state_q == ST_DATA) && !rdy_n;
  assign bus_oe    = !((state_q == ST_FLOAT) || (state_q == ST_HELD));
  assign hlda      = (state_q == ST_HELD);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (hold && !lock_q) state_d = ST_FLOAT;
        else if (req_valid)  state_d = ST_ADDR;
      end
      ST_ADDR: state_d = ST_DATA;
      ST_DATA: begin
        if (!rdy_n) state_d = (hold && !lock_nx) ? ST_FLOAT : ST_IDLE;
      end
      ST_FLOAT: state_d = hold ? ST_HELD : ST_IDLE;
      ST_HELD:  state_d = hold ? ST_HELD : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      defn_q <= '0;
      addr_q <= '0;
      be_q   <= '1;
    end else if (accept) begin
      defn_q <= enc_defn;
      addr_q <= enc_addr;
      be_q   <= enc_be;
    end
  end

  // R3
  ads_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr |=> !in_addr);
  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_addr |=> $stable(addr_q));
  // R4
  done_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |-> $past(in_addr) || (state_q == ST_DATA && $past(state_q) == ST_DATA));
  // R10
  hlda_after_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hlda) |-> $past(!bus_oe));
endmodule

// File: rtl/bus_cycle_issuer.sv
module bus_cycle_issuer
  import bci_pkg::*;
#(
  parameter int AW = 30,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [3:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_be_n,
  input  logic          req_lock,
  input  logic          req_lock_last,
  input  logic          req_more,
  output logic          req_ready,
  input  logic          rdy_n,
  input  logic          ken_n,
  input  logic          hold,
  input  logic          ahold,
  output logic          ads_n,
  output logic          m_io_n,
  output logic          d_c_n,
  output logic          w_r_n,
  output logic [AW-1:0] addr,
  output logic [BW-1:0] be_n,
  output logic          lock_n,
  output logic          plock_n,
  output logic          bus_oe,
  output logic          addr_oe,
  output logic          hlda,
  output logic          cyc_done,
  output logic          fill_ok
);
  logic [2:0]    enc_defn, defn_q;
  logic [AW-1:0] enc_addr;
  logic [BW-1:0] enc_be;
  logic          accept, in_addr, cyc_end;
  logic          lock_q, lock_nx, cur_lock_q, plock_q;
  logic          is_read;

  bci_encode #(.AW(AW), .BW(BW)) u_enc (
    .op(req_op), .addr_in(req_addr), .be_in(req_be_n),
    .defn(enc_defn), .addr_out(enc_addr), .be_out(enc_be)
  );

  bci_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .enc_defn(enc_defn), .enc_addr(enc_addr), .enc_be(enc_be),
    .rdy_n(rdy_n), .hold(hold), .lock_q(lock_q), .lock_nx(lock_nx),
    .accept(accept), .req_ready(req_ready), .in_addr(in_addr),
    .cyc_end(cyc_end), .bus_oe(bus_oe), .hlda(hlda),
    .defn_q(defn_q), .addr_q(addr), .be_q(be_n)
  );

  bci_lock u_lock (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_lock(req_lock),
    .req_lock_last(req_lock_last), .req_more(req_more), .cyc_end(cyc_end),
    .lock_q(lock_q), .lock_nx(lock_nx), .cur_lock_q(cur_lock_q),
    .plock_q(plock_q)
  );

  assign {m_io_n, d_c_n, w_r_n} = defn_q;
  assign ads_n    = !(in_addr && bus_oe);
  assign lock_n   = !(lock_q && bus_oe);
  assign plock_n  = !(plock_q && bus_oe);
  assign addr_oe  = bus_oe && !ahold;
  assign cyc_done = cyc_end;
  assign is_read  = (defn_q == 3'b110) || (defn_q == 3'b100);
  assign fill_ok  = cyc_end && is_read && !ken_n && !cur_lock_q;

  // R6
  no_hlda_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |-> !hlda);
  // R9
  no_locked_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lock_q |-> !fill_ok);
  // R7
  ahold_addr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ahold && !hold && !hlda && bus_oe) |-> !addr_oe);
endmodule

// File: tb/bus_cycle_issuer_test.sv
module bus_cycle_issuer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 30;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_lock, req_lock_last, req_more, rdy_n, ken_n, hold, ahold;
  logic [3:0] req_op;
  logic [AW-1:0] req_addr;
  logic [3:0] req_be_n;
  logic req_ready, ads_n, m_io_n, d_c_n, w_r_n, lock_n, plock_n;
  logic bus_oe, addr_oe, hlda, cyc_done, fill_ok;
  logic [AW-1:0] addr;
  logic [3:0] be_n;

  int checks = 0;
  int fails  = 0;
  bit lock_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_issuer uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_defn(input logic [3:0] op);
    return op[3] ? 3'b001 : op[2:0];
  endfunction
  function automatic logic [3:0] exp_be(input logic [3:0] op, input logic [3:0] be);
    if (op == 4'd8) return 4'b1110;
    if (op[3])      return 4'b1011;
    return be;
  endfunction
  function automatic logic [AW-1:0] exp_addr(input logic [3:0] op, input logic [AW-1:0] a);
    if (op == 4'd10) return AW'(3'b100);
    if (op[3])       return '0;
    return a;
  endfunction

  task automatic run_cyc(input logic [3:0] op, input logic [AW-1:0] a, input logic [3:0] be,
                         input bit lk, input bit lkl, input bit more, input int waits, input bit ken);
    logic [AW-1:0] ea;
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = a; req_be_n = be; req_lock = lk;
    req_lock_last = lkl; req_more = more; req_valid = 1'b1; ken_n = ken;
    @(negedge clk);
    req_valid = 1'b0;
    ea = exp_addr(op, a);
    chk(ads_n == 1'b0, "R3 ads_n low in address phase", 64'(ads_n), 64'd0);
    chk({m_io_n, d_c_n, w_r_n} == exp_defn(op), op[3] ? "R2 special definition" : "R1 definition",
        64'({m_io_n, d_c_n, w_r_n}), 64'(exp_defn(op)));
    chk(addr == ea, op[3] ? "R2 special address" : "R1 address", 64'(addr), 64'(ea));
    chk(be_n == exp_be(op, be), op[3] ? "R2 special byte enables" : "R1 byte enables",
        64'(be_n), 64'(exp_be(op, be)));
    if (lk) lock_m = 1'b1;
    chk(lock_n == !lock_m, "R5 lock_n in address phase", 64'(lock_n), 64'(!lock_m));
    chk(plock_n == !more, "R8 plock_n in address phase", 64'(plock_n), 64'(!more));
    @(negedge clk);
    chk(ads_n == 1'b1 && addr == ea, "R3 strobe one clock, address held", 64'({ads_n, addr}), 64'({1'b1, ea}));
    for (int i = 0; i < waits; i++) begin
      chk(cyc_done == 1'b0, "R4 no end without ready", 64'(cyc_done), 64'd0);
      @(negedge clk);
    end
    rdy_n = 1'b0;
    #1;
    chk(cyc_done == 1'b1, "R4 cyc_done on ready", 64'(cyc_done), 64'd1);
    chk(fill_ok == ((op == 4'd4 || op == 4'd6) && !ken && !lk), "R9 fill permission",
        64'(fill_ok), 64'((op == 4'd4 || op == 4'd6) && !ken && !lk));
    @(negedge clk);
    rdy_n = 1'b1;
    if (lk && lkl) lock_m = 1'b0;
    chk(cyc_done == 1'b0, "R4 single done pulse", 64'(cyc_done), 64'd0);
    if (bus_oe) begin
      chk(lock_n == !lock_m, "R5 lock_n after ready", 64'(lock_n), 64'(!lock_m));
      chk(plock_n == !more, "R8 plock_n kept after ready", 64'(plock_n), 64'(!more));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_valid = 0; req_lock = 0; req_lock_last = 0; req_more = 0;
    rdy_n = 1; ken_n = 1; hold = 0; ahold = 0; req_op = 0; req_addr = '0; req_be_n = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(ads_n && lock_n && plock_n && !hlda && bus_oe && req_ready, "R11 reset state",
        64'({ads_n, lock_n, plock_n, hlda, bus_oe, req_ready}), 64'b111011);

    // directed: every definition and special code
    run_cyc(4'd0, 30'h1234, 4'b0000, 0, 0, 0, 0, 1);
    run_cyc(4'd2, 30'h0044, 4'b1100, 0, 0, 0, 1, 1);
    run_cyc(4'd3, 30'h0045, 4'b0011, 0, 0, 0, 2, 1);
    run_cyc(4'd4, 30'h3FFF_FFFF, 4'b0000, 0, 0, 0, 0, 0);
    run_cyc(4'd6, 30'h0ABC_DEF0, 4'b0000, 0, 0, 0, 3, 0);
    run_cyc(4'd7, 30'h0000_0001, 4'b1110, 0, 0, 0, 0, 0);
    run_cyc(4'd8, 30'h3FFF_FFFF, 4'b0000, 0, 0, 0, 0, 1);
    run_cyc(4'd9, 30'h3FFF_FFFF, 4'b0000, 0, 0, 0, 1, 1);
    run_cyc(4'd10, 30'h3FFF_FFFF, 4'b0000, 0, 0, 0, 0, 1);

    // R8: two-cycle transaction, pseudo-lock released at last address
    run_cyc(4'd6, 30'h100, 4'b0000, 0, 0, 1, 2, 1);
    repeat (2) @(negedge clk);
    chk(plock_n == 1'b0, "R8 plock_n held between cycles", 64'(plock_n), 64'd0);
    run_cyc(4'd6, 30'h101, 4'b0000, 0, 0, 0, 0, 1);

    // R5 R9 R6 R7: locked read-modify-write with hold and ahold
    run_cyc(4'd6, 30'h200, 4'b0000, 1, 0, 0, 1, 0);
    chk(lock_n == 1'b0, "R5 lock_n low between locked cycles", 64'(lock_n), 64'd0);
    hold = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!hlda && bus_oe, "R6 hold not granted while locked", 64'({hlda, bus_oe}), 64'b01);
    end
    ahold = 1'b1;
    #1;
    chk(!addr_oe && bus_oe && !lock_n, "R7 ahold floats address only",
        64'({addr_oe, bus_oe, lock_n}), 64'b010);
    @(negedge clk);
    ahold = 1'b0;
    #1;
    chk(addr_oe == 1'b1, "R7 address driven again", 64'(addr_oe), 64'd1);
    run_cyc(4'd7, 30'h200, 4'b0000, 1, 1, 0, 0, 0);
    chk(!bus_oe && !hlda, "R6 hold granted after unlock, R10 float first",
        64'({bus_oe, hlda}), 64'b00);
    @(negedge clk);
    chk(hlda && !req_ready && !bus_oe, "R10 hlda one clock later",
        64'({hlda, req_ready, bus_oe}), 64'b100);
    chk(lock_n == 1'b1, "R5 lock released", 64'(lock_n), 64'd1);
    hold = 1'b0;
    @(negedge clk);
    chk(bus_oe && !hlda, "R10 bus restored", 64'({bus_oe, hlda}), 64'b10);

    // R10: hold from idle
    hold = 1'b1;
    @(negedge clk);
    chk(!bus_oe && !hlda, "R10 float before acknowledge", 64'({bus_oe, hlda}), 64'b00);
    @(negedge clk);
    chk(hlda && !req_ready, "R10 acknowledge", 64'({hlda, req_ready}), 64'b10);
    hold = 1'b0;
    @(negedge clk);
    chk(bus_oe && !hlda && req_ready, "R10 release", 64'({bus_oe, hlda, req_ready}), 64'b101);

    // random traffic with lock groups and multi-cycle transactions
    for (int g = 0; g < 60; g++) begin
      automatic int n  = 1 + ($urandom % 3);
      automatic bit lk = ($urandom % 3) == 0;
      for (int k = 0; k < n; k++) begin
        automatic logic [3:0] ops [9] = '{4'd0, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9, 4'd10};
        automatic logic [3:0] op = ops[$urandom % 9];
        run_cyc(op, AW'($urandom), 4'($urandom), lk, (k == n - 1), (k != n - 1),
                int'($urandom % 4), 1'($urandom));
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule